// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames on a single input line and presents each byte to a processor through a two-register bus: a data register and a status/configuration register. The line passes through a two-flop synchronizer and is examined on a tick that runs at sixteen times the bit rate. The tick comes from a fixed clock divider parameter. A falling edge starts a frame. The start bit is confirmed at its midpoint, which rejects short glitches. Eight data bits follow, least significant bit first, and then the stop bit is sampled.

Three sticky flags report the outcome of each frame: receive-full, overrun and framing error. A flag clears only through a two-step handshake. Software first reads the status register while the flag is 1, and later writes 0 to that bit. The standby input or reset also clears the flags. While either error flag is set, the receiver accepts no new frame. A frame with a bad stop bit still updates the data register but does not raise receive-full. An overrun leaves the earlier byte in place. The configuration bits select receive enable and a two-stop-bit frame. In two-stop-bit frames only the first stop bit is checked.

Top module: `asyncRxChannel`

## Requirements
- R1: After reset the status register (regSel=1) reads 0x00 and the data register (regSel=0) reads 0x00.
- R2: With receive enable (status bit 0) at 1, a frame with a 1 stop bit loads its 8 data bits into the data register. The bits arrive least significant first. The frame also sets receive-full (status bit 7) when that flag was 0.
- R3: A good frame that ends while receive-full is 1 sets overrun (status bit 6). The data register keeps the earlier byte and receive-full stays 1.
- R4: A frame whose stop sample is 0 sets framing error (status bit 5) and loads the byte into the data register. Receive-full is left unchanged.
- R5: With the two-stop option (status bit 1) set, the first stop bit alone decides framing error. The value of the second stop bit has no effect.
- R6: While overrun or framing error is 1, incoming frames change neither the data register nor any flag.
- R7: Writing 0 to a flag bit clears the flag only if an earlier status read returned that flag as 1. Writing 0 without such a read leaves the flag at 1, and writing 1 never changes a flag.
- R8: With receive enable at 0, frames are ignored. Clearing receive enable leaves all three flags at their previous values.
- R9: Asserting standby for one cycle clears receive-full, overrun and framing error.
- R10: A low pulse on the line shorter than half a bit time does not produce a frame. A following normal frame is received correctly.
- R11: When a flag-clearing write to receive-full lands in the same cycle as a good frame's completion, the clear is applied first. The frame is treated as good: the new byte is loaded, receive-full ends at 1 and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Clears all flags and aborts a frame in progress |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| regSel | input | 1 | Register select: 0 data, 1 status/configuration |
| regRd | input | 1 | Read strobe; a status read arms the flags that read as 1 |
| regWr | input | 1 | Write strobe; only the status register is writable |
| regWdata | input | 8 | Write data: bit 7 receive-full, bit 6 overrun, bit 5 framing error, bit 1 two-stop, bit 0 enable |
| regRdata | output | 8 | Read data of the selected register |

## Verification
The collision that matters is a frame finishing in the same cycle as a software write that clears receive-full. Bus writes and line activity run independently, so the two can meet. The bench reads the status register to arm the flag. It then starts a frame, and in a parallel thread it issues the clearing write after a delay that it sweeps one clock at a time across the whole window around the stop-bit sample. Each trial must end in one of two states. In the first, the clear went first: the new byte is loaded, receive-full is set and overrun is clear. In the second, the clear came late: the old byte remains, receive-full is clear and overrun is set. The sweep must begin in the first state, end in the second, and switch between them exactly once.

// File: rtl/rxChanPkg.sv
package rxChanPkg;
  localparam int DATA_BITS = 8;
  localparam int REG_W     = 8;

  // Status/configuration register bit positions (decoded by software).
  localparam int ST_FULL  = 7;
  localparam int ST_OVR   = 6;
  localparam int ST_FRM   = 5;
  localparam int ST_STOP2 = 1;
  localparam int ST_EN    = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_STOP2
  } rxState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic sampleBit;  // shift the synchronized line into the byte
    logic frameEnd;   // first stop bit is being sampled now
  } rxStrobe_t;
endpackage

// File: rtl/asyncRxTick.sv
module asyncRxTick #(
  parameter int CLKS_PER_TICK = 4  // minimum 2
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = $clog2(CLKS_PER_TICK);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == LAST);
endmodule

// File: rtl/asyncRxCtrl.sv
module asyncRxCtrl
  import rxChanPkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxSync,
  input  logic      rxEnable,
  input  logic      rxBlocked,
  input  logic      stopTwo,
  input  logic      standby,
  output rxStrobe_t strobe
);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int CNT_W = $clog2(OVERSAMPLE + HALF);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] MID_START = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] DWELL_END = CNT_W'(OVERSAMPLE + HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);

  rxState_e          state, nState;
  logic [CNT_W-1:0]  tickCnt, nTickCnt;
  logic [BIT_W-1:0]  bitCnt, nBitCnt;
  logic              abort;

  assign abort = !rxEnable || standby;

  always_comb begin
    nState   = state;
    nTickCnt = tickCnt;
    nBitCnt  = bitCnt;
    strobe   = '0;
    case (state)
      S_IDLE: begin
        if (tick && !rxSync && !rxBlocked) begin
          nState   = S_START;
          nTickCnt = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (tickCnt == MID_START) begin
            nTickCnt = '0;
            nBitCnt  = '0;
            nState   = rxSync ? S_IDLE : S_DATA;
          end else begin
            nTickCnt = tickCnt + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          if (tickCnt == BIT_LAST) begin
            strobe.sampleBit = 1'b1;
            nTickCnt = '0;
            if (bitCnt == LAST_BIT) nState = S_STOP;
            else nBitCnt = bitCnt + 1'b1;
          end else begin
            nTickCnt = tickCnt + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          if (tickCnt == BIT_LAST) begin
            strobe.frameEnd = 1'b1;
            nTickCnt = '0;
            nState   = stopTwo ? S_STOP2 : S_IDLE;
          end else begin
            nTickCnt = tickCnt + 1'b1;
          end
        end
      end
      S_STOP2: begin
        // Dwell to the end of the second stop bit; its value is never used.
        if (tick) begin
          if (tickCnt == DWELL_END) nState = S_IDLE;
          else nTickCnt = tickCnt + 1'b1;
        end
      end
      default: nState = S_IDLE;
    endcase
    if (abort) begin
      nState   = S_IDLE;
      nTickCnt = '0;
      nBitCnt  = '0;
      strobe   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= nState;
      tickCnt <= nTickCnt;
      bitCnt  <= nBitCnt;
    end
  end
endmodule

// File: rtl/asyncRxDatapath.sv
module asyncRxDatapath
  import rxChanPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 standby,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  input  logic                 regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 rxSync,
  output logic                 rxEnable,
  output logic                 stopTwo,
  output logic                 rxBlocked,
  output logic                 rdrfFlag,
  output logic                 orerFlag,
  output logic                 ferFlag,
  output logic [DATA_BITS-1:0] dataReg
);
  logic                 rxMeta;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 armFull, armOvr, armFrm;
  logic                 rdStatus, wrStatus;
  logic                 clrFull, clrOvr, clrFrm;
  logic                 fullEff, stopOk;
  logic                 setFull, setOvr, setFrm, loadData;
  logic [REG_W-1:0]     statusWord;
  logic                 unusedWrBits;

  // Two-flop synchronizer, idle high.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  // LSB-first shift: each new bit enters at the top.
  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.sampleBit) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  assign rdStatus = regRd && regSel;
  assign wrStatus = regWr && regSel;
  assign clrFull  = wrStatus && !regWdata[ST_FULL] && armFull;
  assign clrOvr   = wrStatus && !regWdata[ST_OVR]  && armOvr;
  assign clrFrm   = wrStatus && !regWdata[ST_FRM]  && armFrm;

  // A clear landing with a frame end is applied before the frame is judged.
  assign fullEff  = rdrfFlag && !clrFull;
  assign stopOk   = rxSync;
  assign setFrm   = strobe.frameEnd && !stopOk;
  assign setOvr   = strobe.frameEnd && stopOk && fullEff;
  assign setFull  = strobe.frameEnd && stopOk && !fullEff;
  assign loadData = setFrm || setFull;

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else if (loadData) dataReg <= shiftReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      rdrfFlag <= 1'b0;
      orerFlag <= 1'b0;
      ferFlag  <= 1'b0;
    end else begin
      if (setFull) rdrfFlag <= 1'b1;
      else if (clrFull) rdrfFlag <= 1'b0;
      if (setOvr) orerFlag <= 1'b1;
      else if (clrOvr) orerFlag <= 1'b0;
      if (setFrm) ferFlag <= 1'b1;
      else if (clrFrm) ferFlag <= 1'b0;
    end
  end

  // Arming: a status read records which flags were seen at 1.
  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      armFull <= 1'b0;
      armOvr  <= 1'b0;
      armFrm  <= 1'b0;
    end else if (rdStatus) begin
      armFull <= rdrfFlag;
      armOvr  <= orerFlag;
      armFrm  <= ferFlag;
    end else begin
      if (clrFull) armFull <= 1'b0;
      if (clrOvr)  armOvr  <= 1'b0;
      if (clrFrm)  armFrm  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnable <= 1'b0;
      stopTwo  <= 1'b0;
    end else if (wrStatus) begin
      rxEnable <= regWdata[ST_EN];
      stopTwo  <= regWdata[ST_STOP2];
    end
  end

  assign unusedWrBits = ^regWdata[ST_FRM-1:ST_STOP2+1];

  always_comb begin
    statusWord           = '0;
    statusWord[ST_FULL]  = rdrfFlag;
    statusWord[ST_OVR]   = orerFlag;
    statusWord[ST_FRM]   = ferFlag;
    statusWord[ST_STOP2] = stopTwo;
    statusWord[ST_EN]    = rxEnable;
  end

  assign regRdata  = regSel ? statusWord : REG_W'(dataReg);
  assign rxBlocked = orerFlag || ferFlag;
endmodule

// File: rtl/asyncRxChannel.sv
module asyncRxChannel
  import rxChanPkg::*;
#(
  parameter int CLKS_PER_TICK = 4,
  parameter int OVERSAMPLE    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             rxLine,
  input  logic             regSel,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata
);
  logic                 tick;
  logic                 rxSync, rxEnable, stopTwo, rxBlocked;
  logic                 rdrfFlag, orerFlag, ferFlag;
  logic [DATA_BITS-1:0] dataReg;
  rxStrobe_t            rxStrobe;

  asyncRxTick #(.CLKS_PER_TICK(CLKS_PER_TICK)) uTick (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  asyncRxCtrl #(.OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .rxSync    (rxSync),
    .rxEnable  (rxEnable),
    .rxBlocked (rxBlocked),
    .stopTwo   (stopTwo),
    .standby   (standby),
    .strobe    (rxStrobe)
  );

  asyncRxDatapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .standby   (standby),
    .rxLine    (rxLine),
    .strobe    (rxStrobe),
    .regSel    (regSel),
    .regRd     (regRd),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .rxSync    (rxSync),
    .rxEnable  (rxEnable),
    .stopTwo   (stopTwo),
    .rxBlocked (rxBlocked),
    .rdrfFlag  (rdrfFlag),
    .orerFlag  (orerFlag),
    .ferFlag   (ferFlag),
    .dataReg   (dataReg)
  );
endmodule

// File: rtl/asyncRxChannelChecker.sv
module asyncRxChannelChecker
  import rxChanPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 standby,
  input logic                 regSel,
  input logic                 regWr,
  input logic [REG_W-1:0]     regWdata,
  input logic                 rdrfFlag,
  input logic                 orerFlag,
  input logic                 ferFlag,
  input logic [DATA_BITS-1:0] dataReg,
  input logic                 rxEnable,
  input logic                 frameEnd
);
  assert_ovr_keeps_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(orerFlag) |-> dataReg == $past(dataReg));

  assert_frm_no_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ferFlag) |-> !$rose(rdrfFlag));

  assert_blocked_no_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (orerFlag || ferFlag) |-> !frameEnd);

  assert_single_error_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(orerFlag && ferFlag));

  assert_full_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdrfFlag) |-> $past(standby || (regWr && regSel && !regWdata[ST_FULL])));

  assert_ovr_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(orerFlag) |-> $past(standby || (regWr && regSel && !regWdata[ST_OVR])));

  assert_frm_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ferFlag) |-> $past(standby || (regWr && regSel && !regWdata[ST_FRM])));

  assert_disabled_no_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !frameEnd);

  assert_standby_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!rdrfFlag && !orerFlag && !ferFlag));
endmodule

bind asyncRxChannel asyncRxChannelChecker uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .standby  (standby),
  .regSel   (regSel),
  .regWr    (regWr),
  .regWdata (regWdata),
  .rdrfFlag (rdrfFlag),
  .orerFlag (orerFlag),
  .ferFlag  (ferFlag),
  .dataReg  (dataReg),
  .rxEnable (rxEnable),
  .frameEnd (rxStrobe.frameEnd)
);

// File: tb/asyncRxChannel_test.sv
module asyncRxChannel_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPT        = 4;
  localparam int OVS        = 16;
  localparam int BIT        = CPT * OVS;
  localparam int WATCHDOG   = 190000;
  localparam int KLO        = 590;
  localparam int KHI        = 630;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standby = 1'b0;
  logic       rxLine = 1'b1;
  logic       regSel = 1'b0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  // Bench model of the register state.
  bit       mEn, mStop2, mFull, mOvr, mFrm, aFull, aOvr, aFrm;
  logic [7:0] mData;

  asyncRxChannel #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OVS)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .standby  (standby),
    .rxLine   (rxLine),
    .regSel   (regSel),
    .regRd    (regRd),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expStatus();
    return {mFull, mOvr, mFrm, 3'b000, mStop2, mEn};
  endfunction

  function automatic void mResetAll();
    mEn = 0; mStop2 = 0; mFull = 0; mOvr = 0; mFrm = 0;
    aFull = 0; aOvr = 0; aFrm = 0; mData = 8'h00;
  endfunction

  function automatic void mStatusRead();
    aFull = mFull; aOvr = mOvr; aFrm = mFrm;
  endfunction

  function automatic void mStatusWrite(logic [7:0] wd);
    if (aFull && !wd[7]) begin mFull = 0; aFull = 0; end
    if (aOvr  && !wd[6]) begin mOvr  = 0; aOvr  = 0; end
    if (aFrm  && !wd[5]) begin mFrm  = 0; aFrm  = 0; end
    mEn = wd[0]; mStop2 = wd[1];
  endfunction

  function automatic string mFrame(logic [7:0] b, bit stopOk);
    if (!mEn) return "R8";
    if (mOvr || mFrm) return "R6";
    if (!stopOk) begin mFrm = 1; mData = b; return "R4"; end
    if (mFull) begin mOvr = 1; return "R3"; end
    mData = b; mFull = 1;
    return "R2";
  endfunction

  function automatic void mStandby();
    mFull = 0; mOvr = 0; mFrm = 0; aFull = 0; aOvr = 0; aFrm = 0;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic rawRead(bit sel, output logic [7:0] v);
    regSel = sel; regRd = 1'b1;
    #1 v = regRdata;
    @(posedge clk);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic rawWrite(bit sel, logic [7:0] v);
    regSel = sel; regWr = 1'b1; regWdata = v;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic writeCfg(logic [7:0] v);
    rawWrite(1'b1, v);
    mStatusWrite(v);
  endtask

  task automatic checkStatus(string req, string what);
    logic [7:0] v;
    rawRead(1'b1, v);
    check(req, what, v, expStatus());
    mStatusRead();
  endtask

  task automatic checkData(string req, string what);
    logic [7:0] v;
    rawRead(1'b0, v);
    check(req, what, v, mData);
  endtask

  task automatic sendFrame(logic [7:0] b, bit stop1, bit useTwo, bit stop2v);
    rxLine = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxLine = stop1;
    repeat (BIT) @(negedge clk);
    if (useTwo) begin
      rxLine = stop2v;
      repeat (BIT) @(negedge clk);
    end
    rxLine = 1'b1;
  endtask

  task automatic frame(logic [7:0] b, bit stop1, bit useTwo, bit stop2v, output string tag);
    sendFrame(b, stop1, useTwo, stop2v);
    repeat (2 * BIT) @(negedge clk);
    tag = mFrame(b, stop1);
  endtask

  task automatic pulseStandby();
    standby = 1'b1;
    @(posedge clk);
    @(negedge clk);
    standby = 1'b0;
    mStandby();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    string tag;
    logic [7:0] s, d;
    bit firstA, lastA, prevA;
    int switches;

    mResetAll();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    checkStatus("R1", "status after reset");
    checkData("R1", "data after reset");

    // R2: basic reception, LSB first
    writeCfg(8'h01);
    frame(8'h4B, 1, 0, 0, tag);
    checkStatus("R2", "status after good frame");
    checkData("R2", "data after good frame");

    // R7: writing 1 has no effect, writing 0 after armed read clears
    writeCfg(8'hE1);
    checkStatus("R7", "write of ones keeps flag");
    writeCfg(8'h61);
    checkStatus("R7", "armed write of 0 clears full");
    frame(8'h12, 1, 0, 0, tag);
    writeCfg(8'h01);  // not armed: status not read since the flag rose
    checkStatus("R7", "unarmed write of 0 keeps full");
    writeCfg(8'h01);
    checkStatus("R7", "armed clear after read");

    // R3: overrun keeps earlier byte
    frame(8'h81, 1, 0, 0, tag);
    frame(8'h7E, 1, 0, 0, tag);
    checkStatus("R3", "status after overrun");
    checkData("R3", "data kept on overrun");

    // R6: blocked while overrun is set
    frame(8'h55, 1, 0, 0, tag);
    checkStatus("R6", "status unchanged while blocked");
    checkData("R6", "data unchanged while blocked");
    writeCfg(8'h01);
    checkStatus("R7", "both flags cleared");

    // R4: framing error loads data, no full
    frame(8'h3A, 0, 0, 0, tag);
    checkStatus("R4", "status after framing error");
    checkData("R4", "data loaded on framing error");

    // R8: clearing enable keeps flags
    writeCfg(8'hE0);
    checkStatus("R8", "flags kept when enable cleared");
    writeCfg(8'hE1);
    frame(8'h99, 1, 0, 0, tag);
    checkData("R6", "frame ignored while framing error set");
    writeCfg(8'h01);
    checkStatus("R7", "framing error cleared");

    // R8: disabled receiver ignores frames
    writeCfg(8'h00);
    frame(8'h66, 1, 0, 0, tag);
    checkStatus("R8", "status with receiver disabled");
    checkData("R8", "data with receiver disabled");

    // R5: two stop bits, only first is checked
    writeCfg(8'h03);
    frame(8'hC3, 1, 1, 0, tag);
    checkStatus("R5", "second stop bit low ignored");
    checkData("R5", "data with two stop bits");
    writeCfg(8'h03);
    frame(8'h5A, 0, 1, 1, tag);
    checkStatus("R5", "first stop bit low flags error");
    checkData("R5", "data on first-stop error");
    writeCfg(8'h01);

    // R10: short glitch rejected
    rxLine = 1'b0;
    repeat (3 * CPT) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    checkStatus("R10", "status after glitch");
    checkData("R10", "data after glitch");
    frame(8'h24, 1, 0, 0, tag);
    checkStatus("R10", "status of frame after glitch");
    checkData("R10", "data of frame after glitch");

    // R9: standby clears flags
    frame(8'h42, 1, 0, 0, tag);
    pulseStandby();
    checkStatus("R9", "standby clears full and overrun");
    frame(8'h10, 0, 0, 0, tag);
    pulseStandby();
    checkStatus("R9", "standby clears framing error");

    // Random frames mixed with clears
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      bit ok, two;
      b   = 8'($urandom);
      ok  = ($urandom % 8) != 0;
      two = ($urandom % 4) == 0;
      if (($urandom % 2) == 0) begin
        checkStatus("R7", "random pre-clear read");
        writeCfg({6'b000000, two, 1'b1});
      end
      frame(b, ok, mStop2, 1'($urandom), tag);
      checkStatus(tag, "random frame status");
      checkData(tag, "random frame data");
    end

    // R11: sweep clear write across frame completion
    checkStatus("R11", "pre-sweep read");
    writeCfg(8'h01);
    checkStatus("R11", "pre-sweep clean");
    switches = 0;
    firstA = 0; lastA = 0; prevA = 0;
    for (int k = KLO; k <= KHI; k++) begin
      bit isA, isB;
      sendFrame(8'h3C, 1, 0, 0);
      repeat (2 * BIT) @(negedge clk);
      rawRead(1'b1, s);  // arms receive-full
      fork
        sendFrame(8'hC5, 1, 0, 0);
        begin
          repeat (k) @(negedge clk);
          rawWrite(1'b1, 8'h01);
        end
      join
      repeat (2 * BIT) @(negedge clk);
      rawRead(1'b1, s);
      rawRead(1'b0, d);
      isA = (s == 8'h81) && (d == 8'hC5);
      isB = (s == 8'h41) && (d == 8'h3C);
      checks++;
      if (!(isA || isB)) begin
        fails++;
        $display("FAIL R11 sweep k=%0d: actual=%02h/%02h expected=81/C5 or 41/3C", k, s, d);
      end
      if (k == KLO) firstA = isA;
      else if (isA != prevA) switches++;
      prevA = isA;
      lastA = isA;
      rawWrite(1'b1, 8'h01);
    end
    check("R11", "early clear wins over completion", 8'(firstA), 8'd1);
    check("R11", "late clear follows overrun", 8'(lastA), 8'd0);
    check("R11", "single outcome switch", 8'(switches), 8'd1);
    mStandby();
    mEn = 1; mStop2 = 0;
    mData = 8'h3C;
    checkStatus("R11", "status after sweep");
    checkData("R11", "data after sweep");

    finished = 1'b1;
    finishRun();
  end
endmodule